// File: doc/BRIEF.md
# Multiplexed Bus Byte-Lane Controller

This block turns single memory requests from a processor core into cycles on a 16-bit external bus where the same pins carry the address first and the data afterwards. Each bus cycle has two halves. In the address half the bus clock is low and the pins carry address bits 15..0. In the data half the bus clock is high and the pins carry write data or are released so that read data can be sampled. Six extra outputs carry address bits 19..14 for the whole cycle. A direction line and an active-low lower-lane strobe go with every cycle.

A request is a 20-bit address, a size (byte or 16-bit word), a direction and 16-bit write data. The block places each byte on the correct lane and gathers read bytes from the correct lane. A static mode pin selects a narrow external bus, with data on the upper lane only, or a wide one, with both lanes in use. The pair (strobe, address bit 0) identifies the kind of cycle, and the block chooses it per cycle: an aligned word, an odd byte, an even byte, or an unaligned word in one cycle. The single-cycle unaligned word is only allowed inside a configurable internal-RAM window. Word requests that cannot complete in one cycle are split into two byte cycles.

The request side uses a valid/ready handshake. `req_ready` is high only while the block is idle, and a request is taken on a clock edge where valid and ready are both high. While ready is low, the requester keeps its request, and any change on the request pins has no effect. The response has no back-pressure: `rsp_done` pulses for one clock with `rsp_rdata`.

Top module: `mbus_lane_ctrl`

## Requirements
- R1: `req_ready` is 1 exactly when no transfer is in progress, and a request is taken when `req_valid` and `req_ready` are both 1. Changes on the request pins and `mode_narrow` after acceptance do not affect the transfer in progress.
- R2: Each bus cycle takes one clock with `bus_eclk`=0, `bus_ad_oe`=1 and address bits 15..0 on `bus_ad_out`, then one clock with `bus_eclk`=1. The cycles of a request follow each other with no gap. `rsp_done` is high for one clock, 2N clocks after the accepting edge, where N is the number of bus cycles.
- R3: During every bus cycle `bus_xaddr` equals address bits 19..14 of that cycle. It is 0 when idle.
- R4: `bus_rd` is 1 for read cycles and while idle, and 0 for write cycles. In a read data half `bus_ad_oe` is 0. In a write data half it is 1.
- R5: In wide mode, a word at an even address takes one cycle with strobe 0 and bit 0 = 0. The byte at the address goes on bits 15..8 and the byte at address+1 on bits 7..0.
- R6: In wide mode, a byte at an odd address uses strobe 0 and bits 7..0. A byte at an even address uses strobe 1 and bits 15..8. For a write, the byte comes from `req_wdata[7:0]` and the unused lane is driven 0.
- R7: In wide mode, a word at odd address A with RAM_BASE <= A < RAM_TOP takes one cycle with strobe 1 and bit 0 = 1. The byte at A goes on bits 7..0 and the byte at A+1 on bits 15..8.
- R8: In wide mode, a word at an odd address outside that window becomes two byte cycles, at A and then at A+1 (modulo 2^20). Each follows R6.
- R9: In narrow mode the strobe is always 1, every data byte uses bits 15..8, and bits 7..0 are 0 on writes. A word becomes two cycles, at A then A+1.
- R10: Read results are big-endian. The byte at A is in `rsp_rdata[15:8]` and the byte at A+1 in `rsp_rdata[7:0]`. A byte read returns {8'h00, byte}. A write returns 0.
- R11: After reset: ready 1, bus clock 0, pins released, strobe 1, `bus_rd` 1, `bus_xaddr` 0, `rsp_done` 0, `rsp_rdata` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_narrow | input | 1 | 1: 8-bit external bus on the upper lane, 0: 16-bit bus |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_word | input | 1 | 1: 16-bit access, 0: byte |
| req_rd | input | 1 | 1: read, 0: write |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 16 | Write data, big-endian for words, bits 7..0 for bytes |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read result, valid with `rsp_done` |
| bus_ad_out | output | 16 | Shared address/data pins, driven value |
| bus_ad_oe | output | 1 | Drive enable for the shared pins |
| bus_ad_in | input | 16 | Shared pins, sampled value |
| bus_xaddr | output | 6 | Address bits 19..14 |
| bus_rd | output | 1 | 1 read, 0 write |
| bus_lstrb_n | output | 1 | Active-low lower-lane strobe |
| bus_eclk | output | 1 | Bus clock: low = address half, high = data half |

## Verification
A request accepted at edge E puts its first address half on the pins right after E. Each later half starts one clock after the previous one, so `rsp_done` and the gathered `rsp_rdata` appear together right after edge E+2N. The bench changes inputs and reads outputs only at falling edges. It logs each half at the falling edge inside it, and it counts falling edges from acceptance to the done pulse, expecting exactly 2N. Read data is supplied by a bench responder that models the external memory lanes from the logged address and strobe. Expected results come from a byte-addressed memory function, not from the bus pins.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  localparam int ADDR_W = 20;
  localparam int LANE_W = 8;
  localparam int DATA_W = 2 * LANE_W;
  localparam int XLO    = 14;
  localparam int XW     = ADDR_W - XLO;

  // where the bytes of one bus cycle sit on the pins
  typedef enum logic [1:0] {LN_HI, LN_LO, LN_BOTH, LN_SWAP} lane_e;
  typedef enum logic [1:0] {ST_IDLE, ST_ADR, ST_DAT} state_e;
endpackage

// File: rtl/mbus_cycle_plan.sv
module mbus_cycle_plan
  import mbus_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RAM_BASE = 20'h01000,
  parameter logic [ADDR_W-1:0] RAM_TOP  = 20'h03FFF
) (
  input  logic              narrow,
  input  logic              word,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              idx,
  output logic              two,
  output logic [ADDR_W-1:0] cyc_addr,
  output logic              strb_n,
  output lane_e             lane,
  output logic [DATA_W-1:0] wr_lanes
);
  logic in_ram, odd;
  logic [LANE_W-1:0] byte_v;

  assign odd      = base_addr[0];
  assign in_ram   = (base_addr >= RAM_BASE) && (base_addr < RAM_TOP);
  assign two      = word && (narrow || (odd && !in_ram));
  assign cyc_addr = base_addr + ADDR_W'(idx);
  assign byte_v   = (word && !idx) ? wdata[DATA_W-1:LANE_W] : wdata[LANE_W-1:0];

  always_comb begin
    if (narrow) begin
      lane   = LN_HI;
      strb_n = 1'b1;
    end else if (word && !two) begin
      lane   = odd ? LN_SWAP : LN_BOTH;
      strb_n = odd;
    end else begin
      lane   = cyc_addr[0] ? LN_LO : LN_HI;
      strb_n = ~cyc_addr[0];
    end
  end

  always_comb begin
    case (lane)
      LN_BOTH: wr_lanes = wdata;
      LN_SWAP: wr_lanes = {wdata[LANE_W-1:0], wdata[DATA_W-1:LANE_W]};
      LN_LO:   wr_lanes = {{LANE_W{1'b0}}, byte_v};
      default: wr_lanes = {byte_v, {LANE_W{1'b0}}};
    endcase
  end
endmodule

// File: rtl/mbus_cycle_seq.sv
module mbus_cycle_seq
  import mbus_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   two,
  output state_e state,
  output logic   idx,
  output logic   done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= (state == ST_DAT) && (idx || !two);
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_ADR;
          idx   <= 1'b0;
        end
        ST_ADR:  state <= ST_DAT;
        ST_DAT: begin
          if (two && !idx) begin
            state <= ST_ADR;
            idx   <= 1'b1;
          end else begin
            state <= ST_IDLE;
            idx   <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_single_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_second_only_split_R8: assert property (@(posedge clk) disable iff (!rst_n)
    idx |-> two);
endmodule

// File: rtl/mbus_read_gather.sv
module mbus_read_gather
  import mbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              capture,
  input  lane_e             lane,
  input  logic              split,
  input  logic              idx,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] rdata
);
  logic [LANE_W-1:0] sel;
  assign sel = (lane == LN_LO) ? ad_in[LANE_W-1:0] : ad_in[DATA_W-1:LANE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (clear) begin
      rdata <= '0;
    end else if (capture) begin
      case (lane)
        LN_BOTH: rdata <= ad_in;
        LN_SWAP: rdata <= {ad_in[LANE_W-1:0], ad_in[DATA_W-1:LANE_W]};
        default: begin
          if (!split)   rdata <= {{LANE_W{1'b0}}, sel};
          else if (idx) rdata[LANE_W-1:0] <= sel;
          else          rdata[DATA_W-1:LANE_W] <= sel;
        end
      endcase
    end
  end
endmodule

// File: rtl/mbus_lane_ctrl.sv
module mbus_lane_ctrl
  import mbus_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RAM_BASE = 20'h01000,
  parameter logic [ADDR_W-1:0] RAM_TOP  = 20'h03FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_narrow,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_word,
  input  logic              req_rd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [DATA_W-1:0] bus_ad_out,
  output logic              bus_ad_oe,
  input  logic [DATA_W-1:0] bus_ad_in,
  output logic [XW-1:0]     bus_xaddr,
  output logic              bus_rd,
  output logic              bus_lstrb_n,
  output logic              bus_eclk
);
  logic              narrow_q, word_q, rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              accept, two, idx, strb_n, busy;
  logic [ADDR_W-1:0] cyc_addr;
  logic [DATA_W-1:0] wr_lanes;
  lane_e             lane;
  state_e            state;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      narrow_q <= 1'b0;
      word_q   <= 1'b0;
      rd_q     <= 1'b1;
      addr_q   <= '0;
      wdata_q  <= '0;
    end else if (accept) begin
      narrow_q <= mode_narrow;
      word_q   <= req_word;
      rd_q     <= req_rd;
      addr_q   <= req_addr;
      wdata_q  <= req_wdata;
    end
  end

  mbus_cycle_plan #(.RAM_BASE(RAM_BASE), .RAM_TOP(RAM_TOP)) u_plan (
    .narrow(narrow_q), .word(word_q), .base_addr(addr_q), .wdata(wdata_q),
    .idx(idx), .two(two), .cyc_addr(cyc_addr), .strb_n(strb_n),
    .lane(lane), .wr_lanes(wr_lanes)
  );

  mbus_cycle_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .two(two),
    .state(state), .idx(idx), .done(rsp_done)
  );

  mbus_read_gather u_gather (
    .clk(clk), .rst_n(rst_n), .clear(accept),
    .capture((state == ST_DAT) && rd_q), .lane(lane), .split(two),
    .idx(idx), .ad_in(bus_ad_in), .rdata(rsp_rdata)
  );

  always_comb begin
    bus_eclk    = (state == ST_DAT);
    bus_ad_oe   = (state == ST_ADR) || ((state == ST_DAT) && !rd_q);
    bus_xaddr   = busy ? cyc_addr[ADDR_W-1:XLO] : '0;
    bus_rd      = busy ? rd_q : 1'b1;
    bus_lstrb_n = busy ? strb_n : 1'b1;
    if (state == ST_ADR)                bus_ad_out = cyc_addr[DATA_W-1:0];
    else if (state == ST_DAT && !rd_q)  bus_ad_out = wr_lanes;
    else                                bus_ad_out = '0;
  end

  logic [ADDR_W-1:0] pin_addr;
  assign pin_addr = {bus_xaddr, bus_ad_out[XLO-1:0]};

  assert_ready_only_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!bus_eclk && !bus_ad_oe));
  assert_addr_then_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ad_oe && !bus_eclk) |=> bus_eclk);
  assert_done_after_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> $past(bus_eclk));
  assert_xaddr_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ad_oe && !bus_eclk) |-> (bus_xaddr[1:0] == bus_ad_out[XLO+1:XLO]));
  assert_read_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_eclk && bus_rd) |-> !bus_ad_oe);
  assert_unaligned_in_ram_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ad_oe && !bus_eclk && bus_lstrb_n && bus_ad_out[0] && !narrow_q)
      |-> (pin_addr >= RAM_BASE && pin_addr < RAM_TOP));
  assert_narrow_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && narrow_q) |-> bus_lstrb_n);
endmodule

// File: tb/tb_mbus_lane_ctrl.sv
`timescale 1ns/1ps
module tb_mbus_lane_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_narrow = 1'b0, req_valid = 1'b0, req_word = 1'b0, req_rd = 1'b1;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_done, bus_ad_oe, bus_rd, bus_lstrb_n, bus_eclk;
  logic [15:0] rsp_rdata, bus_ad_out, bus_ad_in;
  logic [5:0]  bus_xaddr;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  mbus_lane_ctrl dut (
    .clk(clk), .rst_n(rst_n), .mode_narrow(mode_narrow), .req_valid(req_valid),
    .req_ready(req_ready), .req_word(req_word), .req_rd(req_rd), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in),
    .bus_xaddr(bus_xaddr), .bus_rd(bus_rd), .bus_lstrb_n(bus_lstrb_n), .bus_eclk(bus_eclk)
  );

  // external memory contents as a function of the byte address
  function automatic logic [7:0] mb(input logic [19:0] a);
    return a[7:0] ^ {a[15:12], a[19:16]} ^ 8'h3C;
  endfunction

  // bench responder and bus logger
  logic        cur_nar = 1'b0, ph_strb = 1'b1;
  logic [19:0] ph_addr = '0;
  logic [19:0] lg_addr [4];
  logic [15:0] lg_data [4];
  logic        lg_strb [4], lg_rw [4], lg_oe [4];
  int          lg_n = 0;
  bit          lg_bad = 0;

  always_comb begin
    if (cur_nar)                  bus_ad_in = {mb(ph_addr), 8'h00};
    else if (ph_strb && ph_addr[0]) bus_ad_in = {mb(ph_addr + 20'd1), mb(ph_addr)};
    else bus_ad_in = {mb({ph_addr[19:1], 1'b0}), mb({ph_addr[19:1], 1'b1})};
  end

  always @(negedge clk) begin
    if (rst_n && !bus_eclk && bus_ad_oe && lg_n < 4) begin
      ph_addr = {bus_xaddr, bus_ad_out[13:0]};
      ph_strb = bus_lstrb_n;
      if (bus_xaddr[1:0] != bus_ad_out[15:14]) lg_bad = 1;
      lg_addr[lg_n] = ph_addr;
      lg_strb[lg_n] = bus_lstrb_n;
      lg_rw[lg_n]   = bus_rd;
    end else if (rst_n && bus_eclk && lg_n < 4) begin
      lg_data[lg_n] = bus_ad_out;
      lg_oe[lg_n]   = bus_ad_oe;
      lg_n++;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic run_req(input logic nar, input logic wd, input logic rd,
                         input logic [19:0] a, input logic [15:0] d,
                         input int exp_n, input bit scramble);
    int j;
    string tag;
    logic [7:0] b;
    logic [15:0] exp_lanes, exp_rd;
    logic exp_s;
    logic [19:0] ca;
    mode_narrow = nar; req_word = wd; req_rd = rd; req_addr = a; req_wdata = d;
    cur_nar = nar; lg_n = 0; lg_bad = 0;
    chk(req_ready == 1'b1, "R1", "ready before request", 32'(req_ready), 1);
    req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (scramble) begin
      req_wdata = ~d; req_addr = ~a; mode_narrow = ~nar; req_rd = ~rd; req_word = ~wd;
    end
    j = 0;
    @(negedge clk);
    chk(req_ready == 1'b0, "R1", "ready while busy", 32'(req_ready), 0);
    while (!rsp_done && j < 40) begin j++; @(negedge clk); end
    chk(j == 2 * exp_n, "R2", "clocks to done", 32'(j), 32'(2 * exp_n));
    chk(lg_n == exp_n, "R2", "bus cycle count", 32'(lg_n), 32'(exp_n));
    chk(req_ready == 1'b1, "R1", "ready with done", 32'(req_ready), 1);
    chk(!lg_bad, "R3", "xaddr overlap bits", 32'(lg_bad), 0);
    if (nar) tag = "R9";
    else if (exp_n == 2) tag = "R8";
    else if (!wd) tag = "R6";
    else if (a[0]) tag = "R7";
    else tag = "R5";
    for (int i = 0; i < exp_n && i < lg_n; i++) begin
      ca = a + 20'(i);
      chk(lg_addr[i] == ca, "R3", "cycle address", 32'(lg_addr[i]), 32'(ca));
      chk(lg_rw[i] == rd, "R4", "direction", 32'(lg_rw[i]), 32'(rd));
      chk(lg_oe[i] == !rd, "R4", "data-half drive", 32'(lg_oe[i]), 32'(!rd));
      b = (wd && i == 0) ? d[15:8] : d[7:0];
      if (nar) begin
        exp_s = 1'b1; exp_lanes = {b, 8'h00};
      end else if (wd && exp_n == 1) begin
        exp_s = a[0]; exp_lanes = a[0] ? {d[7:0], d[15:8]} : d;
      end else begin
        exp_s = ~ca[0]; exp_lanes = ca[0] ? {8'h00, b} : {b, 8'h00};
      end
      chk(lg_strb[i] == exp_s, tag, "strobe", 32'(lg_strb[i]), 32'(exp_s));
      if (!rd) chk(lg_data[i] == exp_lanes, tag, "write lanes", 32'(lg_data[i]), 32'(exp_lanes));
    end
    if (!rd) exp_rd = 16'h0000;
    else if (wd) exp_rd = {mb(a), mb(a + 20'd1)};
    else exp_rd = {8'h00, mb(a)};
    chk(rsp_rdata == exp_rd, rd ? "R10" : "R10", "result data", 32'(rsp_rdata), 32'(exp_rd));
  endtask

  // {narrow, word, rd, cycles[1:0], addr[19:0], wdata[15:0]}
  localparam logic [40:0] VEC [16] = '{
    {1'b0, 1'b1, 1'b1, 2'd1, 20'h12344, 16'h0000},
    {1'b0, 1'b1, 1'b0, 2'd1, 20'h00A10, 16'hBEEF},
    {1'b0, 1'b0, 1'b1, 2'd1, 20'h20005, 16'h0000},
    {1'b0, 1'b0, 1'b0, 2'd1, 20'h40006, 16'h11C3},
    {1'b0, 1'b0, 1'b0, 2'd1, 20'h00007, 16'h225A},
    {1'b0, 1'b1, 1'b1, 2'd1, 20'h01235, 16'h0000},
    {1'b0, 1'b1, 1'b0, 2'd2, 20'h03FFF, 16'h1357},
    {1'b0, 1'b1, 1'b1, 2'd2, 20'h08001, 16'h0000},
    {1'b1, 1'b1, 1'b1, 2'd2, 20'h10010, 16'h0000},
    {1'b1, 1'b1, 1'b0, 2'd2, 20'h00203, 16'h9ABC},
    {1'b1, 1'b0, 1'b0, 2'd1, 20'h00204, 16'h6677},
    {1'b1, 1'b0, 1'b1, 2'd1, 20'hFFFFF, 16'h0000},
    {1'b0, 1'b1, 1'b0, 2'd2, 20'hFFFFF, 16'h2468},
    {1'b1, 1'b1, 1'b1, 2'd2, 20'h01001, 16'h0000},
    {1'b0, 1'b1, 1'b0, 2'd1, 20'h01000, 16'h0F0F},
    {1'b0, 1'b1, 1'b0, 2'd1, 20'h01001, 16'hA5A5}
  };

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(req_ready == 1'b1, "R11", "ready", 32'(req_ready), 1);
    chk(bus_eclk == 1'b0 && bus_ad_oe == 1'b0, "R11", "clock/drive", {bus_eclk, bus_ad_oe}, 0);
    chk(bus_lstrb_n == 1'b1 && bus_rd == 1'b1, "R11", "strobe/dir", {bus_lstrb_n, bus_rd}, 3);
    chk(bus_xaddr == 6'd0, "R3", "idle xaddr", 32'(bus_xaddr), 0);
    chk(rsp_done == 1'b0 && rsp_rdata == 16'h0, "R11", "response", {rsp_done, rsp_rdata}, 0);

    for (int k = 0; k < 16; k++) begin
      run_req(VEC[k][40], VEC[k][39], VEC[k][38], VEC[k][35:16], VEC[k][15:0],
              int'(VEC[k][37:36]), 1'b0);
      @(negedge clk);
    end

    // R1: request pins and mode changed during transfers have no effect
    run_req(1'b0, 1'b1, 1'b0, 20'h05002, 16'hC001, 1, 1'b1);
    run_req(1'b1, 1'b1, 1'b1, 20'h00FFE, 16'h0000, 2, 1'b1);
    // back-to-back with no idle gap after done
    run_req(1'b0, 1'b0, 1'b1, 20'h00FFE, 16'h0000, 1, 1'b0);
    // R7 window edge just below base is split
    run_req(1'b0, 1'b1, 1'b1, 20'h00FFF, 16'h0000, 2, 1'b0);
    @(negedge clk);
    chk(bus_xaddr == 6'd0 && bus_rd == 1'b1, "R3", "idle after traffic", {bus_xaddr, bus_rd}, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule